// File: doc/BRIEF.md
# Protection Unit Configuration Registers

This block is the software-visible register file that sits beside a region-based memory protection checker. It holds the global switches, a window of per-region registers reached through a region-selection register, and the fault capture state. A processor bus writes and reads it through a simple word-addressed port that carries a privilege flag. The settings of every region leave the block at once on wide parallel buses, so the checker can compare all regions in the same cycle.

Each region owns a base register and an attribute register. Software picks the region either with the selection register, or by placing a region number in the low bits of a base write together with a valid flag. In the second case, that one write also moves the window. On read-back, base bits that fall inside the region's own size read as zero. When the checker reports a violation, the block sets a sticky flag for an instruction or a data access. A data violation also records the offending address.

Top module: `prot_cfg_regs`

## Requirements
- R1: After reset, control, region selection, every base and attribute register, the fault flags and the fault address all read zero. The enable outputs are low.
- R2: Offset 0 is read-only. It reads NUM_REGIONS in bits [15:8] and zero elsewhere, and writes to it change nothing.
- R3: Control at offset 1 has three writable bits: global enable in bit 0, fault-handler enforcement in bit 1 and privileged background enable in bit 2. They drive `prot_en`, `prot_hf_en` and `prot_bg_en`. Its other bits read zero.
- R4: Region selection at offset 2 stores bits [3:0] of the write data and reads them back. Base and attribute accesses address the selected region.
- R5: A base write (offset 3) with bit 4 set stores bits [31:5] into the region named by bits [3:0] and also loads that number into the selection register. With bit 4 clear, the write goes to the selected region and bits [4:0] are ignored.
- R6: Base reads return the stored address with bits below 2^(SIZE+1) forced to zero, where SIZE is attribute bits [5:1]. SIZE 31 clears the whole address. Bits [3:0] read the selected region number and bit 4 reads zero. The region's `rgn_base` slice carries the same masked address with bits [4:0] zero.
- R7: Attribute writes (offset 4) keep bit 0, bits [5:1], bits [15:8], bits [21:16], bits [26:24] and bit 28, and clear all other bits. Region i's attribute appears on `rgn_attr[32*i+31:32*i]`.
- R8: A write with `bus_priv` low changes no register.
- R9: A reported violation sets a sticky flag at offset 5: bit 0 for an instruction fetch, bit 1 for a data access. A privileged write of 1 clears a flag. A violation in the same cycle wins over the clear.
- R10: The fault address at offset 6 loads `flt_addr` on a data violation only. It holds its value otherwise, and a bus write cannot change it.
- R11: Each region keeps its own settings. Regions whose address ranges overlap are stored and driven out independently. Offset 7 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | Access is privileged |
| bus_ofs | input | OFS_W | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| flt_valid | input | 1 | Checker reports a violation this cycle |
| flt_fetch | input | 1 | Violation was an instruction fetch |
| flt_addr | input | 32 | Address of the violating access |
| prot_en | output | 1 | Global protection enable |
| prot_hf_en | output | 1 | Enforcement in fault handlers |
| prot_bg_en | output | 1 | Privileged background region enable |
| rgn_base | output | 32*NUM_REGIONS | Masked base address of every region |
| rgn_attr | output | 32*NUM_REGIONS | Attribute word of every region |

## Verification
The bench builds the block with the default of 16 regions. All four bits of the embedded region number are therefore live, and the retargeting base write can reach every bank, including the highest one. Random writes mix privilege levels, embedded-number flags and size exponents from 0 to 31, so masking is exercised from no effect up to a fully cleared address. Violations are injected in the same cycle as flag-clearing writes.

// File: rtl/prot_cfg_regs.sv
module prot_cfg_regs #(
  parameter int NUM_REGIONS = 16,
  parameter int OFS_W       = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_sel,
  input  logic                      bus_wr,
  input  logic                      bus_priv,
  input  logic [OFS_W-1:0]          bus_ofs,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  input  logic                      flt_valid,
  input  logic                      flt_fetch,
  input  logic [31:0]               flt_addr,
  output logic                      prot_en,
  output logic                      prot_hf_en,
  output logic                      prot_bg_en,
  output logic [32*NUM_REGIONS-1:0] rgn_base,
  output logic [32*NUM_REGIONS-1:0] rgn_attr
);
  localparam int RN_W = 4;
  localparam logic [31:0] ATTR_KEEP = 32'h173F_FF3F;
  localparam logic [31:0] TYPE_VAL  = 32'(NUM_REGIONS) << 8;
  localparam logic [OFS_W-1:0] O_TYPE = 0, O_CTRL = 1, O_RNUM = 2, O_BASE = 3,
                               O_ATTR = 4, O_FSTAT = 5, O_FADDR = 6;

  logic [2:0]      ctrl_q;
  logic [RN_W-1:0] rnum_q;
  logic [1:0]      fs_q;
  logic [31:0]     far_q;

  wire wr_ok    = bus_sel & bus_wr & bus_priv;
  wire wr_base  = wr_ok && bus_ofs == O_BASE;
  wire wr_attr  = wr_ok && bus_ofs == O_ATTR;
  wire wr_fstat = wr_ok && bus_ofs == O_FSTAT;
  wire retarget = wr_base && bus_wdata[4];
  wire [RN_W-1:0] base_tgt = retarget ? bus_wdata[RN_W-1:0] : rnum_q;
  wire dflt = flt_valid & ~flt_fetch;
  wire iflt = flt_valid & flt_fetch;

  function automatic logic [31:0] keep_mask(input logic [4:0] sz);
    keep_mask = (sz == 5'd31) ? 32'd0 : ~((32'd1 << (sz + 5'd1)) - 32'd1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rnum_q <= '0;
      fs_q   <= '0;
      far_q  <= '0;
    end else begin
      if (wr_ok && bus_ofs == O_CTRL) ctrl_q <= bus_wdata[2:0];
      if ((wr_ok && bus_ofs == O_RNUM) || retarget) rnum_q <= bus_wdata[RN_W-1:0];
      fs_q <= (fs_q & ~(wr_fstat ? bus_wdata[1:0] : 2'b00)) | {dflt, iflt};
      if (dflt) far_q <= flt_addr;
    end
  end

  assign prot_en    = ctrl_q[0];
  assign prot_hf_en = ctrl_q[1];
  assign prot_bg_en = ctrl_q[2];

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
    logic [26:0] base_q;
    logic [31:0] attr_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= '0;
        attr_q <= '0;
      end else begin
        if (wr_base && base_tgt == RN_W'(g)) base_q <= bus_wdata[31:5];
        if (wr_attr && rnum_q == RN_W'(g))   attr_q <= bus_wdata & ATTR_KEEP;
      end
    end
    assign rgn_base[32*g +: 32] = {base_q, 5'b0} & keep_mask(attr_q[5:1]);
    assign rgn_attr[32*g +: 32] = attr_q;
  end

  wire        sel_ok   = 32'(rnum_q) < NUM_REGIONS;
  wire [31:0] sel_base = sel_ok ? rgn_base[32*int'(rnum_q) +: 32] : 32'd0;
  wire [31:0] sel_attr = sel_ok ? rgn_attr[32*int'(rnum_q) +: 32] : 32'd0;

  always_comb begin
    case (bus_ofs)
      O_TYPE:  bus_rdata = TYPE_VAL;
      O_CTRL:  bus_rdata = {29'd0, ctrl_q};
      O_RNUM:  bus_rdata = {{(32-RN_W){1'b0}}, rnum_q};
      O_BASE:  bus_rdata = sel_base | {{(32-RN_W){1'b0}}, rnum_q};
      O_ATTR:  bus_rdata = sel_attr;
      O_FSTAT: bus_rdata = {30'd0, fs_q};
      O_FADDR: bus_rdata = far_q;
      default: bus_rdata = 32'd0;
    endcase
  end

  p_unpriv_ctrl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !bus_priv) |=> $stable(ctrl_q));
  p_unpriv_rnum_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !bus_priv) |=> $stable(rnum_q));
  p_dflag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && !flt_fetch) |=> fs_q[1]);
  p_iflag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_q[0] && !(wr_fstat && bus_wdata[0])) |=> fs_q[0]);
  p_faddr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(flt_valid && !flt_fetch) |=> $stable(far_q));
  p_faddr_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && !flt_fetch) |=> far_q == $past(flt_addr));
endmodule

// File: tb/prot_cfg_regs_tb.sv
module prot_cfg_regs_tb;
  localparam int NR = 16;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0, bus_priv = 0;
  logic [2:0] bus_ofs = 0;
  logic [31:0] bus_wdata = 0, flt_addr = 0;
  logic flt_valid = 0, flt_fetch = 0;
  logic [31:0] bus_rdata;
  logic prot_en, prot_hf_en, prot_bg_en;
  logic [32*NR-1:0] rgn_base, rgn_attr;

  prot_cfg_regs #(.NUM_REGIONS(NR), .OFS_W(3)) u_dut (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_priv, .bus_ofs, .bus_wdata, .bus_rdata,
    .flt_valid, .flt_fetch, .flt_addr, .prot_en, .prot_hf_en, .prot_bg_en,
    .rgn_base, .rgn_attr);

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [26:0] m_base [NR];
  logic [31:0] m_attr [NR];
  logic [2:0]  m_ctrl;
  logic [3:0]  m_rnum;
  logic [1:0]  m_fs;
  logic [31:0] m_far;

  function automatic logic [31:0] e_mask(input logic [4:0] sz);
    if (sz == 5'd31) return 32'd0;
    return ~((32'd1 << (int'(sz) + 1)) - 32'd1);
  endfunction

  function automatic logic [31:0] e_base(input int i);
    return {m_base[i], 5'b0} & e_mask(m_attr[i][5:1]);
  endfunction

  function automatic logic [31:0] e_read(input logic [2:0] o);
    case (o)
      3'd0: return 32'd16 << 8;
      3'd1: return {29'd0, m_ctrl};
      3'd2: return {28'd0, m_rnum};
      3'd3: return e_base(int'(m_rnum)) | {28'd0, m_rnum};
      3'd4: return m_attr[m_rnum];
      3'd5: return {30'd0, m_fs};
      3'd6: return m_far;
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic pv, input logic [2:0] o,
                      input logic [31:0] d, input logic fv, input logic ff,
                      input logic [31:0] fa);
    logic [3:0] t;
    @(negedge clk);
    bus_sel = wr; bus_wr = wr; bus_priv = pv; bus_ofs = o; bus_wdata = d;
    flt_valid = fv; flt_fetch = ff; flt_addr = fa;
    if (wr && pv) begin
      case (o)
        3'd1: m_ctrl = d[2:0];
        3'd2: m_rnum = d[3:0];
        3'd3: begin
          t = d[4] ? d[3:0] : m_rnum;
          if (d[4]) m_rnum = d[3:0];
          m_base[t] = d[31:5];
        end
        3'd4: m_attr[m_rnum] = d & 32'h173F_FF3F;
        3'd5: m_fs = m_fs & ~d[1:0];
        default: ;
      endcase
    end
    if (fv) begin
      if (ff) m_fs[0] = 1'b1;
      else begin m_fs[1] = 1'b1; m_far = fa; end
    end
    @(posedge clk);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; flt_valid = 0;
  endtask

  task automatic rd(input string req, input logic [2:0] o);
    bus_ofs = o; #1;
    chk(req, bus_rdata, e_read(o));
  endtask

  task automatic outs(input string req);
    chk(req, {29'd0, prot_bg_en, prot_hf_en, prot_en}, {29'd0, m_ctrl});
    for (int i = 0; i < NR; i++) begin
      chk(req, rgn_base[32*i +: 32], e_base(i));
      chk(req, rgn_attr[32*i +: 32], m_attr[i]);
    end
  endtask

  initial begin
    #1600000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    for (int i = 0; i < NR; i++) begin m_base[i] = 0; m_attr[i] = 0; end
    m_ctrl = 0; m_rnum = 0; m_fs = 0; m_far = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int o = 0; o < 8; o++) rd("R1", 3'(o));
    outs("R1");
    // R2 type register read-only
    step(1, 1, 3'd0, 32'hFFFF_FFFF, 0, 0, 0);
    rd("R2", 3'd0);
    // R3 control bits
    step(1, 1, 3'd1, 32'hFFFF_FFFD, 0, 0, 0);
    rd("R3", 3'd1); outs("R3");
    // R8 unprivileged write blocked
    step(1, 0, 3'd1, 32'h0, 0, 0, 0);
    rd("R8", 3'd1);
    step(1, 0, 3'd2, 32'h9, 0, 0, 0);
    rd("R8", 3'd2);
    // R4 selection and overlapping regions, R11
    step(1, 1, 3'd2, 32'h0, 0, 0, 0);
    step(1, 1, 3'd4, 32'hFFFF_FFFF & ~32'h3E | (32'd19 << 1), 0, 0, 0);
    step(1, 1, 3'd3, 32'h2000_0000, 0, 0, 0);
    step(1, 1, 3'd2, 32'h5, 0, 0, 0);
    rd("R4", 3'd2);
    step(1, 1, 3'd4, (32'd9 << 1) | 32'h1, 0, 0, 0);
    step(1, 1, 3'd3, 32'h2000_0400, 0, 0, 0);
    rd("R7", 3'd4); rd("R11", 3'd3); outs("R11");
    // R6 masking: 1 KB region
    step(1, 1, 3'd3, 32'h1234_5678, 0, 0, 0);
    rd("R6", 3'd3);
    step(1, 1, 3'd4, 32'd31 << 1, 0, 0, 0);
    rd("R6", 3'd3);
    // R5 retarget with valid bit, then ignored number without it
    step(1, 1, 3'd3, 32'h4000_0000 | 32'h1F, 0, 0, 0);
    rd("R5", 3'd2); outs("R5");
    step(1, 1, 3'd3, 32'h5000_0000 | 32'h03, 0, 0, 0);
    rd("R5", 3'd2); outs("R5");
    // R9, R10 faults
    step(0, 0, 3'd0, 0, 1, 1, 32'hAAAA_0000);
    rd("R9", 3'd5); rd("R10", 3'd6);
    step(0, 0, 3'd0, 0, 1, 0, 32'hBEEF_0004);
    rd("R9", 3'd5); rd("R10", 3'd6);
    step(1, 1, 3'd6, 32'h0, 0, 0, 0);
    rd("R10", 3'd6);
    step(1, 1, 3'd5, 32'h3, 1, 1, 32'h0);
    rd("R9", 3'd5);
    step(1, 0, 3'd5, 32'h3, 0, 0, 0);
    rd("R9", 3'd5);
    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [2:0] o;
      logic [31:0] d;
      o = 3'($urandom % 8);
      d = $urandom;
      if ($urandom % 3 == 0) d[5:1] = 5'($urandom % 32);
      step(($urandom % 5) != 0, ($urandom % 4) != 0, o, d,
           ($urandom % 6) == 0, 1'($urandom), $urandom);
      rd("R11", 3'($urandom % 8));
      if (k % 50 == 0) outs("R7");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule